// File: doc/BRIEF.md
# Hiccup Overload and Thermal Protection Controller

This block decides whether a regulated supply output may conduct. It watches a digital overload comparator and two thermal comparators, and drives one output-enable line and two diagnostic flags. The overload flag reports current trouble. The thermal flag reports an overheated junction. The output is cut while the junction is hot, and it resumes once the temperature has dropped below the lower threshold.

The overload handling has two modes, chosen by a mode input. In the dynamic (hiccup) mode, an overload switches the output off for a long window of `T_OFF_CYC` clocks. The output then comes back on for a retry window one tenth as long. An overload seen at any point in the retry window starts a new off window. Only a retry window with no overload in it returns the block to normal running and clears the flag. In the static mode, the output stays on and the flag copies the synchronised overload input. Analog clamping and current sensing are done outside the block.

The controller has five states. `S_IDLE` is the state while the block is disabled. `S_RUN` is dynamic-mode normal running. `S_OFF` is the hiccup off window and `S_RETRY` is the hiccup retry window. `S_STATIC` is the static mode.

Transitions are evaluated in priority order:
- The enable input low moves every state to `S_IDLE`.
- Otherwise, the static mode input high moves every state to `S_STATIC`.
- Otherwise, `S_IDLE` and `S_STATIC` go to `S_RUN`.
- `S_RUN` goes to `S_OFF` on an overload.
- `S_OFF` goes to `S_RETRY` after `T_OFF_CYC` cycles.
- `S_RETRY` goes to `S_OFF` on an overload. After `T_OFF_CYC/10` clean cycles it goes to `S_RUN`.

Top module: `hiccup_guard`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, `out_on`, `ovl_flag` and `hot_flag` are all 0. The first clock edge after reset with `run_en`=1 and `static_mode`=0 gives `out_on`=1 and `ovl_flag`=0.
- R2: When `run_en` is 0 at a clock edge, both `out_on` and `ovl_flag` are 0 after that edge, even in the middle of a hiccup cycle. `run_en` returning to 1 resumes normal running on the next edge.
- R3: The overload input passes through two synchroniser flops. In dynamic mode (`static_mode`=0), `ovl_in` driven high before edge k gives `out_on`=0 and `ovl_flag`=1 after edge k+2, and not earlier.
- R4: The off window lasts exactly `T_OFF_CYC` cycles. During it, `out_on`=0 and `ovl_flag`=1, and `ovl_in` has no effect on its length.
- R5: The retry window lasts `T_OFF_CYC/10` cycles. During it, `out_on`=1 and `ovl_flag` stays 1.
- R6: A synchronised overload seen in any cycle of the retry window, including its last one, starts a new full off window.
- R7: Only after a full retry window with no overload does the block return to normal running, with `ovl_flag`=0 and `out_on`=1.
- R8: In static mode, `out_on` stays 1. `ovl_flag` equals `ovl_in` delayed by two clock edges, both when it rises and when it falls.
- R9: Raising `static_mode` during a hiccup cycle gives `out_on`=1 after the next edge. Lowering it again resumes dynamic normal running with `ovl_flag`=0.
- R10: `hot_flag` is set by `temp_hi`=1 at an edge, with `temp_hi` winning when both thermal inputs are high. Once set, it is held until an edge with `temp_cool`=1 and `temp_hi`=0.
- R11: While `hot_flag` is 1, `out_on` is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_in | input | 1 | Overload comparator output, asynchronous |
| static_mode | input | 1 | 1 selects static reporting, 0 selects hiccup mode |
| run_en | input | 1 | Enables the power path; 0 holds the controller idle |
| temp_hi | input | 1 | Junction above the upper thermal threshold |
| temp_cool | input | 1 | Junction below the lower thermal threshold |
| out_on | output | 1 | Output stage enable |
| ovl_flag | output | 1 | Overload diagnostic flag |
| hot_flag | output | 1 | Over-temperature diagnostic flag |

## Verification
The bench places a one-cycle overload pulse at every cycle of the retry window, including the final one, and also runs one clean retry. A design that lets the last retry cycle slip would return to normal running with the overload still present. A design with an off-by-one window count is caught by exact checks at both edges of each window. Those checks also sample on either side of the two-flop latency, so missing or extra synchroniser stages show up. A single-cycle pulse inside the off window catches a design that restarts its off timer on every overload. A mode switch and an enable drop in mid-hiccup catch a design that leaves the output dark or the flag stuck. Driving both thermal inputs high, and idling between the two thresholds, checks the hysteresis priority.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RUN    = 3'd1,
        S_OFF    = 3'd2,
        S_RETRY  = 3'd3,
        S_STATIC = 3'd4
    } prot_state_t;

    localparam int unsigned RETRY_DIV = 10;

endpackage

// File: rtl/hg_sync.sv
module hg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hg_thermal.sv
module hg_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hi,
    input  logic temp_cool,
    output logic hot_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hot_q <= 1'b0;
        else if (temp_hi)   hot_q <= 1'b1;
        else if (temp_cool) hot_q <= 1'b0;
    end

    AST_HOT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hi |=> hot_q);                        // R10
    AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_q && !temp_cool) |=> hot_q);          // R10

endmodule

// File: rtl/hg_fsm.sv
module hg_fsm
    import hiccup_pkg::*;
#(
    parameter int unsigned T_OFF_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovl_s,
    input  logic static_mode,
    input  logic run_en,
    output logic on_req,
    output logic flag_o
);

    localparam int unsigned T_ON_CYC = T_OFF_CYC / RETRY_DIV;
    localparam int unsigned CW       = $clog2(T_OFF_CYC);
    localparam logic [CW-1:0] OFF_LAST = CW'(T_OFF_CYC - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(T_ON_CYC - 1);

    prot_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!run_en) begin
            state_d = S_IDLE;
            cnt_d   = '0;
        end else if (static_mode) begin
            state_d = S_STATIC;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                S_IDLE, S_STATIC: begin
                    state_d = S_RUN;
                    cnt_d   = '0;
                end
                S_RUN: begin
                    if (ovl_s) begin
                        state_d = S_OFF;
                        cnt_d   = '0;
                    end
                end
                S_OFF: begin
                    if (cnt_q == OFF_LAST) begin
                        state_d = S_RETRY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_RETRY: begin
                    if (ovl_s) begin
                        state_d = S_OFF;
                        cnt_d   = '0;
                    end else if (cnt_q == ON_LAST) begin
                        state_d = S_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:   begin on_req = 1'b0; flag_o = 1'b0;  end
            S_RUN:    begin on_req = 1'b1; flag_o = 1'b0;  end
            S_OFF:    begin on_req = 1'b0; flag_o = 1'b1;  end
            S_RETRY:  begin on_req = 1'b1; flag_o = 1'b1;  end
            S_STATIC: begin on_req = 1'b1; flag_o = ovl_s; end
            default:  begin on_req = 1'b0; flag_o = 1'b0;  end
        endcase
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == S_IDLE));                                   // R2
    AST_TRIP_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !static_mode && state_q == S_RUN && ovl_s)
            |=> (state_q == S_OFF));                                        // R3
    AST_OFF_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RETRY && $past(state_q) == S_OFF)
            |-> ($past(cnt_q) == OFF_LAST));                                // R4
    AST_RETRY_RETRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !static_mode && state_q == S_RETRY && ovl_s)
            |=> (state_q == S_OFF));                                        // R6
    AST_CLEAN_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && $past(state_q) == S_RETRY)
            |-> ($past(cnt_q) == ON_LAST && !$past(ovl_s)));                // R7
    AST_STATIC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && static_mode) |=> (state_q == S_STATIC));                 // R9

endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard #(
    parameter int unsigned T_OFF_CYC   = 40,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovl_in,
    input  logic static_mode,
    input  logic run_en,
    input  logic temp_hi,
    input  logic temp_cool,
    output logic out_on,
    output logic ovl_flag,
    output logic hot_flag
);

    logic ovl_s;
    logic on_req;

    hg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ovl_in),
        .q_sync  (ovl_s)
    );

    hg_fsm #(.T_OFF_CYC(T_OFF_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovl_s       (ovl_s),
        .static_mode (static_mode),
        .run_en      (run_en),
        .on_req      (on_req),
        .flag_o      (ovl_flag)
    );

    hg_thermal u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_hi   (temp_hi),
        .temp_cool (temp_cool),
        .hot_q     (hot_flag)
    );

    assign out_on = on_req & ~hot_flag;

    AST_HOT_CUTS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hi |=> !out_on);                      // R11

endmodule

// File: tb/sim_hiccup_guard.sv
module sim_hiccup_guard;

    localparam int TOFF = 40;
    localparam int TON  = TOFF / 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovl_in = 1'b0, static_mode = 1'b0, run_en = 1'b1;
    logic temp_hi = 1'b0, temp_cool = 1'b0;
    logic out_on, ovl_flag, hot_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    hiccup_guard #(.T_OFF_CYC(TOFF), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ovl_in(ovl_in), .static_mode(static_mode),
        .run_en(run_en), .temp_hi(temp_hi), .temp_cool(temp_cool),
        .out_on(out_on), .ovl_flag(ovl_flag), .hot_flag(hot_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // Trip from S_RUN: ovl_in raised now; ends at the negedge after the entry edge of the off window.
    task automatic trip();
        ovl_in = 1'b1;
        tick(2);
        chk("R3 output still on before sync latency", out_on, 1'b1);
        tick(1);
        chk("R3 output cut", out_on, 1'b0);
        chk("R3 flag raised", ovl_flag, 1'b1);
        ovl_in = 1'b0;
    endtask

    initial begin
        fork
            begin : main_seq
                tick(2);
                chk("R1 out_on in reset", out_on, 1'b0);
                chk("R1 ovl_flag in reset", ovl_flag, 1'b0);
                chk("R1 hot_flag in reset", hot_flag, 1'b0);
                rst_n = 1'b1;
                tick(1);
                chk("R1 running after reset", out_on, 1'b1);
                chk("R1 flag clear after reset", ovl_flag, 1'b0);

                // Sweep: overload pulse at each retry offset k, k == TON is a clean retry.
                for (int k = 0; k <= TON; k++) begin
                    trip();
                    tick(5);
                    ovl_in = 1'b1;      // R4: pulse inside off window
                    tick(1);
                    ovl_in = 1'b0;
                    tick(TOFF - 9);
                    chk("R4 still off late in window", out_on, 1'b0);
                    chk("R4 flag high in window", ovl_flag, 1'b1);
                    if (k == TON) begin
                        tick(2);
                        chk("R4 off through last cycle", out_on, 1'b0);
                        tick(1);
                        chk("R5 retry output on", out_on, 1'b1);
                        chk("R5 flag held in retry", ovl_flag, 1'b1);
                        tick(TON - 1);
                        chk("R5 retry last cycle on", out_on, 1'b1);
                        chk("R5 flag still high", ovl_flag, 1'b1);
                        tick(1);
                        chk("R7 flag cleared after clean retry", ovl_flag, 1'b0);
                        chk("R7 output on after clean retry", out_on, 1'b1);
                    end else begin
                        tick(k + 1);
                        ovl_in = 1'b1;
                        tick(1);
                        ovl_in = 1'b0;
                        tick(1);
                        chk("R6 retry on before retrip", out_on, 1'b1);
                        tick(1);
                        chk("R6 retrip cuts output", out_on, 1'b0);
                        chk("R6 flag high on retrip", ovl_flag, 1'b1);
                        tick(TOFF - 1);
                        chk("R6 new off window full length", out_on, 1'b0);
                        tick(TON + 1);
                        chk("R7 recovered after restart", out_on, 1'b1);
                        chk("R7 flag clear after restart", ovl_flag, 1'b0);
                    end
                    tick(3);
                end

                // R8: static mode.
                static_mode = 1'b1;
                tick(1);
                ovl_in = 1'b1;
                tick(1);
                chk("R8 flag not yet up", ovl_flag, 1'b0);
                tick(1);
                chk("R8 flag follows overload", ovl_flag, 1'b1);
                chk("R8 output stays on", out_on, 1'b1);
                tick(5);
                chk("R8 output on under long overload", out_on, 1'b1);
                ovl_in = 1'b0;
                tick(1);
                chk("R8 flag still up one edge after drop", ovl_flag, 1'b1);
                tick(1);
                chk("R8 flag drops", ovl_flag, 1'b0);
                static_mode = 1'b0;
                tick(2);

                // R9: switch to static mid hiccup.
                trip();
                tick(2);
                static_mode = 1'b1;
                tick(1);
                chk("R9 static restores output", out_on, 1'b1);
                chk("R9 static flag clear", ovl_flag, 1'b0);
                static_mode = 1'b0;
                tick(1);
                chk("R9 dynamic normal after static", out_on, 1'b1);
                chk("R9 flag clear after static", ovl_flag, 1'b0);
                tick(2);

                // R2: enable drop mid hiccup.
                trip();
                tick(3);
                run_en = 1'b0;
                tick(1);
                chk("R2 disabled output off", out_on, 1'b0);
                chk("R2 disabled flag clear", ovl_flag, 1'b0);
                ovl_in = 1'b1;
                tick(4);
                chk("R2 overload ignored while disabled", ovl_flag, 1'b0);
                ovl_in = 1'b0;
                tick(3);
                run_en = 1'b1;
                tick(1);
                chk("R2 re-enable resumes", out_on, 1'b1);
                chk("R2 re-enable flag clear", ovl_flag, 1'b0);

                // R10/R11: thermal hysteresis.
                temp_hi = 1'b1;
                tick(1);
                chk("R10 hot set", hot_flag, 1'b1);
                chk("R11 hot cuts output", out_on, 1'b0);
                temp_hi = 1'b0;
                tick(4);
                chk("R10 hot held in band", hot_flag, 1'b1);
                temp_hi = 1'b1;
                temp_cool = 1'b1;
                tick(1);
                chk("R10 hi wins over cool", hot_flag, 1'b1);
                temp_hi = 1'b0;
                tick(1);
                chk("R10 cooled clears", hot_flag, 1'b0);
                chk("R11 output back on", out_on, 1'b1);
                temp_cool = 1'b0;
                static_mode = 1'b1;
                temp_hi = 1'b1;
                tick(1);
                chk("R11 hot cuts static output", out_on, 1'b0);
                temp_hi = 1'b0;
                temp_cool = 1'b1;
                tick(1);
                chk("R11 static output back", out_on, 1'b1);
                temp_cool = 1'b0;
                tick(2);
            end
            begin : watchdog
                wait (cycles > 100000);
                failures++;
                $display("FAIL watchdog expired at cycle %0d", cycles);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule